// File: doc/BRIEF.md
# MSI Capability Register File

This block holds the registers of a message-signalled interrupt capability in a PCI function's configuration space. Software reaches it with dword accesses. Each access carries byte enables and a dword index counted from the capability base. The block keeps:

- the message control word,
- the message address,
- the 16-bit message data value,
- and, when masking is built in, a per-vector mask word and a per-vector pending word.

Three build options shape the register set: 64-bit addressing, per-vector masking, and the log2 of the number of vectors the function may request. They decide which registers exist, where the later registers sit, and which bits software may write. The window of valid offsets follows from these options.

A message dispatcher beside the block uses the decoded values: enable, the enabled vector count, address, data, mask and pending. The dispatcher sets and clears pending bits through two vector inputs. A one-cycle write-hit pulse tells it to re-examine pending vectors after any write that lands in the window. Two rules keep the state legal. If software enables the function with a vector count above what is advertised, the count is pulled down to the advertised value. At the same time, pending bits for vectors beyond the enabled count are dropped.

Top module: `msi_cap_regs`

## Requirements
- R1: Reset (rstN low, asynchronous) clears the enable bit, the enabled-count field, both address words, the data register, the mask word and the pending word, and all outputs read zero. The read-only capability bits are unaffected.
- R2: Dword 0 returns the control word in bits 31:16. Within it: bit 16 is the enable, bits 19:17 the advertised log2 vector count (CAP_LOG2), bits 22:20 the enabled log2 count, bit 23 reads the 64-bit option and bit 24 reads the masking option. Bits 15:0 and 31:25 read zero.
- R3: In the control word only the enable and the enabled-count field are writable, and only when byte enable 2 is set. A write with byte enable 2 clear changes nothing.
- R4: After any write inside the window that leaves the enable set, an enabled count above CAP_LOG2 is replaced by CAP_LOG2. While the enable is clear, the field keeps any written value.
- R5: Dword 1 is the low address, and its bits 1:0 always read zero. With 64-bit addressing, dword 2 is a fully writable high address. msgAddr presents {high, low}, with the high half zero when 64-bit addressing is not built in.
- R6: The data register sits at dword 3 with 64-bit addressing and at dword 2 without. Only its bits 15:0 are writable, and bits 31:16 read zero.
- R7: With masking built in, the mask word follows the data register. Only bits 0 to 2^CAP_LOG2-1 are writable; all other bits stay zero.
- R8: With masking built in, the pending word follows the mask. Software cannot write it. Each cycle a bit is set by pendSet, or cleared by pendClr when not also set, and only bits below 2^CAP_LOG2 can be one. Without masking, pending reads zero.
- R9: After a write inside the window that leaves masking present and the enable set, pending bits at or above 2^(enabled count) are cleared in that same update. A pendSet in the same cycle is applied afterwards.
- R10: The window is 0x0A, 0x0E, 0x14 or 0x18 bytes for the four option combinations (32-bit/64-bit, without/with masking). A dword whose byte offset is at or past the window length reads zero and ignores writes. A read returns data only when accValid is high and accWrite is low.
- R11: writeHit is high for exactly the cycle after a write that lands inside the window, with any byte enables, including a write to a read-only location.
- R12: Writes update only the bytes whose byte enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low function reset |
| accValid | input | 1 | Access request this cycle |
| accWrite | input | 1 | 1 for write, 0 for read |
| accAddr | input | IDX_W | Dword index from the capability base |
| accByteEn | input | 4 | Byte enables for the write |
| accWdata | input | 32 | Write data |
| rdData | output | 32 | Read data, combinational in the request cycle |
| pendSet | input | 32 | Dispatcher requests to set pending bits |
| pendClr | input | 32 | Dispatcher requests to clear pending bits |
| msiEnable | output | 1 | Decoded enable |
| vecCountLog2 | output | 3 | Enabled log2 vector count |
| msgAddr | output | 64 | Message address |
| msgData | output | 16 | Message data |
| vecMask | output | 32 | Per-vector mask |
| vecPending | output | 32 | Per-vector pending |
| writeHit | output | 1 | Pulse after a write inside the window |

## Verification
Two builds run side by side on the same stimulus. One has 64-bit addressing, masking and 8 vectors. The other has 32-bit addressing, no masking and 2 vectors. Running both separates the layout shift of the data, mask and pending registers and the changing window length. Directed control writes try the enable with and without an oversize count, and with byte enable 2 missing. These separate the clamp from a plain write and from a dropped write. Partial byte enables, writes to read-only and out-of-window offsets, and simultaneous set and clear of pending bits come next. A long random stretch mixes them all, and every output and read value is compared with a behavioural model on every clock.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_CTRL,
    RD_ALO,
    RD_AHI,
    RD_DATA,
    RD_MASK,
    RD_PEND
  } rdSel_e;

  // Strobes from the decoder to the register datapath.
  typedef struct packed {
    logic       hit;
    logic       isWrite;
    logic       wrCtrl;
    logic       wrAddrLo;
    logic       wrAddrHi;
    logic       wrData;
    logic       wrMask;
    logic [3:0] byteEn;
    rdSel_e     rdSel;
  } capStrobe_t;

  // Window length in bytes for a build-option combination.
  function automatic int capLengthBytes(input bit addr64, input bit perVecMask);
    if (addr64) return perVecMask ? 'h18 : 'h0E;
    return perVecMask ? 'h14 : 'h0A;
  endfunction

  function automatic logic [31:0] byteMerge(input logic [31:0] oldVal,
                                            input logic [31:0] newVal,
                                            input logic [3:0]  be);
    logic [31:0] res;
    for (int b = 0; b < 4; b++) res[8*b +: 8] = be[b] ? newVal[8*b +: 8] : oldVal[8*b +: 8];
    return res;
  endfunction

  // Bits 0 .. 2^lg-1 set.
  function automatic logic [31:0] vecLowMask(input logic [2:0] lg);
    logic [31:0] m;
    for (int i = 0; i < 32; i++) m[i] = (i < (1 << lg));
    return m;
  endfunction

endpackage

// File: rtl/msi_cap_ctrl.sv
module msi_cap_ctrl
  import msi_cap_pkg::*;
#(
  parameter bit ADDR64       = 1'b1,
  parameter bit PER_VEC_MASK = 1'b1,
  parameter int IDX_W        = 6
) (
  input  logic             accValid,
  input  logic             accWrite,
  input  logic [IDX_W-1:0] accAddr,
  input  logic [3:0]       accByteEn,
  output capStrobe_t       stb
);

  localparam int CAP_LEN = capLengthBytes(ADDR64, PER_VEC_MASK);
  localparam int WIN_DW  = (CAP_LEN + 3) / 4;
  localparam int DATA_I  = ADDR64 ? 3 : 2;
  localparam int MASK_I  = DATA_I + 1;
  localparam int PEND_I  = MASK_I + 1;

  localparam logic [IDX_W-1:0] WIN_END  = IDX_W'(WIN_DW);
  localparam logic [IDX_W-1:0] IDX_CTRL = IDX_W'(0);
  localparam logic [IDX_W-1:0] IDX_ALO  = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_AHI  = IDX_W'(2);
  localparam logic [IDX_W-1:0] IDX_DATA = IDX_W'(DATA_I);
  localparam logic [IDX_W-1:0] IDX_MASK = IDX_W'(MASK_I);
  localparam logic [IDX_W-1:0] IDX_PEND = IDX_W'(PEND_I);

  logic   inWin;
  rdSel_e target;

  always_comb begin
    inWin  = (accAddr < WIN_END);
    target = RD_NONE;
    if (accAddr == IDX_CTRL)                         target = RD_CTRL;
    else if (accAddr == IDX_ALO)                     target = RD_ALO;
    else if (ADDR64 && accAddr == IDX_AHI)           target = RD_AHI;
    else if (accAddr == IDX_DATA)                    target = RD_DATA;
    else if (PER_VEC_MASK && accAddr == IDX_MASK)    target = RD_MASK;
    else if (PER_VEC_MASK && accAddr == IDX_PEND)    target = RD_PEND;
  end

  always_comb begin
    stb        = '0;
    stb.byteEn = accByteEn;
    stb.rdSel  = RD_NONE;
    if (accValid && inWin) begin
      stb.hit     = 1'b1;
      stb.isWrite = accWrite;
      if (accWrite) begin
        stb.wrCtrl   = (target == RD_CTRL);
        stb.wrAddrLo = (target == RD_ALO);
        stb.wrAddrHi = (target == RD_AHI);
        stb.wrData   = (target == RD_DATA);
        stb.wrMask   = (target == RD_MASK);
      end else begin
        stb.rdSel = target;
      end
    end
  end

endmodule

// File: rtl/msi_cap_datapath.sv
module msi_cap_datapath
  import msi_cap_pkg::*;
#(
  parameter bit ADDR64       = 1'b1,
  parameter bit PER_VEC_MASK = 1'b1,
  parameter int CAP_LOG2     = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  capStrobe_t  stb,
  input  logic [31:0] accWdata,
  input  logic [31:0] pendSet,
  input  logic [31:0] pendClr,
  output logic [31:0] rdData,
  output logic        msiEnable,
  output logic [2:0]  vecCountLog2,
  output logic [63:0] msgAddr,
  output logic [15:0] msgData,
  output logic [31:0] vecMask,
  output logic [31:0] vecPending,
  output logic        writeHit
);

  localparam int          NVEC       = 1 << CAP_LOG2;
  localparam logic [63:0] CAP_MASK_W = (64'd1 << NVEC) - 64'd1;
  localparam logic [31:0] CAP_MASK   = CAP_MASK_W[31:0];
  localparam logic [2:0]  CAP_FIELD  = 3'(CAP_LOG2);
  localparam logic [31:0] ALO_WMASK  = 32'hFFFF_FFFC;

  logic        enQ, enD;
  logic [2:0]  qQ, qD;
  logic [31:0] aloQ, aloD;
  logic [15:0] dataQ, dataD;
  logic [31:0] ahiQ, maskQ, pendQ;
  logic        wrHitQ;
  logic        wrAny;

  assign wrAny = stb.hit && stb.isWrite;

  always_comb begin
    enD   = enQ;
    qD    = qQ;
    aloD  = aloQ;
    dataD = dataQ;
    if (stb.wrCtrl && stb.byteEn[2]) begin
      enD = accWdata[16];
      qD  = accWdata[22:20];
    end
    // Clamp the enabled count once the function is enabled.
    if (wrAny && enD && (qD > CAP_FIELD)) qD = CAP_FIELD;
    if (stb.wrAddrLo) aloD = byteMerge(aloQ, accWdata, stb.byteEn) & ALO_WMASK;
    if (stb.wrData) begin
      if (stb.byteEn[0]) dataD[7:0]  = accWdata[7:0];
      if (stb.byteEn[1]) dataD[15:8] = accWdata[15:8];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ    <= 1'b0;
      qQ     <= '0;
      aloQ   <= '0;
      dataQ  <= '0;
      wrHitQ <= 1'b0;
    end else begin
      enQ    <= enD;
      qQ     <= qD;
      aloQ   <= aloD;
      dataQ  <= dataD;
      wrHitQ <= wrAny;
    end
  end

  generate
    if (ADDR64) begin : gAddrHi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)             ahiQ <= '0;
        else if (stb.wrAddrHi) ahiQ <= byteMerge(ahiQ, accWdata, stb.byteEn);
      end
    end else begin : gNoAddrHi
      assign ahiQ = '0;
    end
  endgenerate

  generate
    if (PER_VEC_MASK) begin : gMask
      logic [31:0] trimmed;
      logic [31:0] pendD;

      always_comb begin
        trimmed = pendQ;
        if (wrAny && enD) trimmed = pendQ & vecLowMask(qD);
        pendD = ((trimmed & ~pendClr) | pendSet) & CAP_MASK;
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          maskQ <= '0;
          pendQ <= '0;
        end else begin
          if (stb.wrMask) maskQ <= byteMerge(maskQ, accWdata, stb.byteEn) & CAP_MASK;
          pendQ <= pendD;
        end
      end

      // R7
      mask_range_chk: assert property (@(posedge clk) disable iff (!rstN)
        (vecMask & ~CAP_MASK) == 32'h0);

      // R8
      pend_range_chk: assert property (@(posedge clk) disable iff (!rstN)
        (vecPending & ~CAP_MASK) == 32'h0);

      // R8
      pend_set_chk: assert property (@(posedge clk) disable iff (!rstN)
        ((pendSet & CAP_MASK) != 32'h0) |=>
          ((vecPending & $past(pendSet & CAP_MASK)) == $past(pendSet & CAP_MASK)));
    end else begin : gNoMask
      assign maskQ = '0;
      assign pendQ = '0;
    end
  endgenerate

  always_comb begin
    case (stb.rdSel)
      RD_CTRL: rdData = {7'b0, PER_VEC_MASK, ADDR64, qQ, CAP_FIELD, enQ, 16'h0};
      RD_ALO:  rdData = aloQ;
      RD_AHI:  rdData = ahiQ;
      RD_DATA: rdData = {16'h0, dataQ};
      RD_MASK: rdData = maskQ;
      RD_PEND: rdData = pendQ;
      default: rdData = '0;
    endcase
  end

  assign msiEnable    = enQ;
  assign vecCountLog2 = qQ;
  assign msgAddr      = {ahiQ, aloQ};
  assign msgData      = dataQ;
  assign vecMask      = maskQ;
  assign vecPending   = pendQ;
  assign writeHit     = wrHitQ;

  // R10
  one_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrCtrl, stb.wrAddrLo, stb.wrAddrHi, stb.wrData, stb.wrMask}));

  // R3
  en_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.wrCtrl && stb.byteEn[2]) |=> $stable(msiEnable));

  // R4
  count_clamp_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrAny |=> (!msiEnable || vecCountLog2 <= CAP_FIELD));

  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wrAddrLo |=> $stable(msgAddr[31:0]));

  // R6
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wrData |=> $stable(msgData));

  // R11
  write_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrAny |=> writeHit);

  // R11
  write_hit_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrAny |=> !writeHit);

endmodule

// File: rtl/msi_cap_regs.sv
module msi_cap_regs
  import msi_cap_pkg::*;
#(
  parameter bit ADDR64       = 1'b1,
  parameter bit PER_VEC_MASK = 1'b1,
  parameter int CAP_LOG2     = 3,
  parameter int IDX_W        = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             accValid,
  input  logic             accWrite,
  input  logic [IDX_W-1:0] accAddr,
  input  logic [3:0]       accByteEn,
  input  logic [31:0]      accWdata,
  output logic [31:0]      rdData,
  input  logic [31:0]      pendSet,
  input  logic [31:0]      pendClr,
  output logic             msiEnable,
  output logic [2:0]       vecCountLog2,
  output logic [63:0]      msgAddr,
  output logic [15:0]      msgData,
  output logic [31:0]      vecMask,
  output logic [31:0]      vecPending,
  output logic             writeHit
);

  capStrobe_t stb;

  msi_cap_ctrl #(
    .ADDR64      (ADDR64),
    .PER_VEC_MASK(PER_VEC_MASK),
    .IDX_W       (IDX_W)
  ) u_ctrl (
    .accValid (accValid),
    .accWrite (accWrite),
    .accAddr  (accAddr),
    .accByteEn(accByteEn),
    .stb      (stb)
  );

  msi_cap_datapath #(
    .ADDR64      (ADDR64),
    .PER_VEC_MASK(PER_VEC_MASK),
    .CAP_LOG2    (CAP_LOG2)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .accWdata    (accWdata),
    .pendSet     (pendSet),
    .pendClr     (pendClr),
    .rdData      (rdData),
    .msiEnable   (msiEnable),
    .vecCountLog2(vecCountLog2),
    .msgAddr     (msgAddr),
    .msgData     (msgData),
    .vecMask     (vecMask),
    .vecPending  (vecPending),
    .writeHit    (writeHit)
  );

endmodule

// File: tb/msi_cap_regs_tb.sv
module msi_cap_regs_tb;

  localparam int NCFG = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b1;
  logic        accValid = 1'b0;
  logic        accWrite = 1'b0;
  logic [5:0]  accAddr = '0;
  logic [3:0]  accByteEn = '0;
  logic [31:0] accWdata = '0;
  logic [31:0] pendSet = '0;
  logic [31:0] pendClr = '0;

  logic [31:0] oRd   [NCFG];
  logic        oEn   [NCFG];
  logic [2:0]  oQ    [NCFG];
  logic [63:0] oAddr [NCFG];
  logic [15:0] oData [NCFG];
  logic [31:0] oMask [NCFG];
  logic [31:0] oPend [NCFG];
  logic        oWh   [NCFG];

  always #5 clk = ~clk;

  msi_cap_regs #(.ADDR64(1'b1), .PER_VEC_MASK(1'b1), .CAP_LOG2(3), .IDX_W(6)) u_dut (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite), .accAddr(accAddr),
    .accByteEn(accByteEn), .accWdata(accWdata), .rdData(oRd[0]), .pendSet(pendSet),
    .pendClr(pendClr), .msiEnable(oEn[0]), .vecCountLog2(oQ[0]), .msgAddr(oAddr[0]),
    .msgData(oData[0]), .vecMask(oMask[0]), .vecPending(oPend[0]), .writeHit(oWh[0]));

  msi_cap_regs #(.ADDR64(1'b0), .PER_VEC_MASK(1'b0), .CAP_LOG2(1), .IDX_W(6)) u_dut_b (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite), .accAddr(accAddr),
    .accByteEn(accByteEn), .accWdata(accWdata), .rdData(oRd[1]), .pendSet(pendSet),
    .pendClr(pendClr), .msiEnable(oEn[1]), .vecCountLog2(oQ[1]), .msgAddr(oAddr[1]),
    .msgData(oData[1]), .vecMask(oMask[1]), .vecPending(oPend[1]), .writeHit(oWh[1]));

  bit cfgA64 [NCFG] = '{1'b1, 1'b0};
  bit cfgPvm [NCFG] = '{1'b1, 1'b0};
  int cfgCl  [NCFG] = '{3, 1};

  // Behavioural reference state
  bit          mEn   [NCFG] = '{1'b0, 1'b0};
  int          mQ    [NCFG] = '{0, 0};
  logic [31:0] mAlo  [NCFG] = '{32'h0, 32'h0};
  logic [31:0] mAhi  [NCFG] = '{32'h0, 32'h0};
  logic [15:0] mData [NCFG] = '{16'h0, 16'h0};
  logic [31:0] mMask [NCFG] = '{32'h0, 32'h0};
  logic [31:0] mPend [NCFG] = '{32'h0, 32'h0};
  bit          mWh   [NCFG] = '{1'b0, 1'b0};

  int    vectors = 0;
  int    miscompares = 0;
  bit    done = 1'b0;
  bit    started = 1'b0;
  string curReq = "R1";

  function automatic logic [31:0] lowBits(input int n);
    logic [63:0] t;
    if (n >= 32) return 32'hFFFF_FFFF;
    t = (64'd1 << n) - 64'd1;
    return t[31:0];
  endfunction

  function automatic int capLen(input int k);
    if (cfgA64[k]) return cfgPvm[k] ? 24 : 14;
    return cfgPvm[k] ? 20 : 10;
  endfunction

  function automatic logic [31:0] mrg(input logic [31:0] o, input logic [31:0] n,
                                      input logic [3:0] be);
    logic [31:0] r;
    r = o;
    if (be[0]) r[7:0]   = n[7:0];
    if (be[1]) r[15:8]  = n[15:8];
    if (be[2]) r[23:16] = n[23:16];
    if (be[3]) r[31:24] = n[31:24];
    return r;
  endfunction

  function automatic logic [31:0] expRead(input int k);
    int idx;
    idx = int'(accAddr);
    if (!(accValid && !accWrite && (idx * 4 < capLen(k)))) return 32'h0;
    if (idx == 0) return {7'b0, cfgPvm[k], cfgA64[k], 3'(mQ[k]), 3'(cfgCl[k]), mEn[k], 16'h0};
    if (idx == 1) return mAlo[k];
    if (cfgA64[k] && idx == 2) return mAhi[k];
    if (idx == (cfgA64[k] ? 3 : 2)) return {16'h0, mData[k]};
    if (cfgPvm[k] && idx == (cfgA64[k] ? 4 : 3)) return mMask[k];
    if (cfgPvm[k] && idx == (cfgA64[k] ? 5 : 4)) return mPend[k];
    return 32'h0;
  endfunction

  task automatic stepModel(input int k);
    logic [31:0] capM;
    int idx;
    bit hit;
    bit wr;
    capM = lowBits(1 << cfgCl[k]);
    idx  = int'(accAddr);
    hit  = accValid && (idx * 4 < capLen(k));
    wr   = hit && accWrite;
    mWh[k] = wr;
    if (wr) begin
      if (idx == 0) begin
        if (accByteEn[2]) begin
          mEn[k] = accWdata[16];
          mQ[k]  = int'(accWdata[22:20]);
        end
      end else if (idx == 1) begin
        mAlo[k] = mrg(mAlo[k], accWdata, accByteEn) & 32'hFFFF_FFFC;
      end else if (cfgA64[k] && idx == 2) begin
        mAhi[k] = mrg(mAhi[k], accWdata, accByteEn);
      end else if (idx == (cfgA64[k] ? 3 : 2)) begin
        if (accByteEn[0]) mData[k][7:0]  = accWdata[7:0];
        if (accByteEn[1]) mData[k][15:8] = accWdata[15:8];
      end else if (cfgPvm[k] && idx == (cfgA64[k] ? 4 : 3)) begin
        mMask[k] = mrg(mMask[k], accWdata, accByteEn) & capM;
      end
      if (mEn[k] && mQ[k] > cfgCl[k]) mQ[k] = cfgCl[k];
      if (mEn[k] && cfgPvm[k]) mPend[k] = mPend[k] & lowBits(1 << mQ[k]);
    end
    if (cfgPvm[k]) mPend[k] = ((mPend[k] & ~pendClr) | pendSet) & capM;
    else           mPend[k] = 32'h0;
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < NCFG; k++) begin
        mEn[k] = 1'b0; mQ[k] = 0; mAlo[k] = '0; mAhi[k] = '0;
        mData[k] = '0; mMask[k] = '0; mPend[k] = '0; mWh[k] = 1'b0;
      end
    end else begin
      for (int k = 0; k < NCFG; k++) stepModel(k);
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int k,
                     input logic [63:0] act, input logic [63:0] exp);
    if (!ok) begin
      miscompares++;
      $display("FAIL %s cfg%0d %s: actual %h expected %h", req, k, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      for (int k = 0; k < NCFG; k++) begin
        logic [63:0] expAddr;
        logic [31:0] expRd;
        expAddr = cfgA64[k] ? {mAhi[k], mAlo[k]} : {32'h0, mAlo[k]};
        expRd   = expRead(k);
        vectors++;
        chk(oRd[k] == expRd, curReq, "rdData", k, 64'(oRd[k]), 64'(expRd));
        chk(oEn[k] == mEn[k], "R3", "msiEnable", k, 64'(oEn[k]), 64'(mEn[k]));
        chk(oQ[k] == 3'(mQ[k]), "R4", "vecCountLog2", k, 64'(oQ[k]), 64'(mQ[k]));
        chk(oAddr[k] == expAddr, "R5", "msgAddr", k, oAddr[k], expAddr);
        chk(oData[k] == mData[k], "R6", "msgData", k, 64'(oData[k]), 64'(mData[k]));
        chk(oMask[k] == mMask[k], "R7", "vecMask", k, 64'(oMask[k]), 64'(mMask[k]));
        chk(oPend[k] == mPend[k], "R8", "vecPending", k, 64'(oPend[k]), 64'(mPend[k]));
        chk(oWh[k] == mWh[k], "R11", "writeHit", k, 64'(oWh[k]), 64'(mWh[k]));
      end
    end
  end

  task automatic op(input bit v, input bit w, input int a, input logic [3:0] be,
                    input logic [31:0] wd, input logic [31:0] s, input logic [31:0] c);
    @(posedge clk);
    #2;
    accValid = v; accWrite = w; accAddr = 6'(a);
    accByteEn = be; accWdata = wd; pendSet = s; pendClr = c;
  endtask

  task automatic wr(input int a, input logic [3:0] be, input logic [31:0] wd);
    op(1'b1, 1'b1, a, be, wd, 32'h0, 32'h0);
  endtask

  task automatic rd(input int a);
    op(1'b1, 1'b0, a, 4'h0, 32'h0, 32'h0, 32'h0);
  endtask

  task automatic idle();
    op(1'b0, 1'b0, 0, 4'h0, 32'h0, 32'h0, 32'h0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #2 rstN = 1'b0;
    started = 1'b1;
    curReq = "R1";
    repeat (3) idle();
    rstN = 1'b1;
    for (int a = 0; a < 8; a++) rd(a);

    curReq = "R2";
    rd(0);

    curReq = "R3";
    wr(0, 4'hF, 32'hFFFE_FFFF);
    rd(0);
    wr(0, 4'b1011, 32'hFFFF_FFFF);
    rd(0);

    curReq = "R4";
    wr(0, 4'b0100, 32'h0071_0000);
    rd(0);
    wr(0, 4'b0100, 32'h0011_0000);
    rd(0);
    wr(0, 4'b0100, 32'h0060_0000);
    rd(0);
    wr(1, 4'hF, 32'h0000_0010);
    rd(0);
    wr(0, 4'b0100, 32'h0061_0000);
    rd(0);

    curReq = "R5";
    wr(1, 4'hF, 32'hFFFF_FFFF);
    rd(1);
    wr(2, 4'hF, 32'hDEAD_BEEF);
    rd(2);
    rd(3);

    curReq = "R12";
    wr(1, 4'b0010, 32'h0000_5A00);
    rd(1);
    wr(2, 4'b1000, 32'h7700_0000);
    rd(2);

    curReq = "R6";
    wr(3, 4'hF, 32'h1234_ABCD);
    rd(3);
    rd(2);
    wr(3, 4'b0010, 32'h0000_EE00);
    rd(3);

    curReq = "R7";
    wr(4, 4'hF, 32'hFFFF_FFFF);
    rd(4);
    wr(3, 4'hF, 32'hFFFF_FFFF);
    rd(3);
    wr(4, 4'b0001, 32'h0000_0000);
    rd(4);

    curReq = "R8";
    op(1'b0, 1'b0, 0, 4'h0, 32'h0, 32'h0000_00A5, 32'h0);
    op(1'b1, 1'b0, 5, 4'h0, 32'h0, 32'hFFFF_0000, 32'h0);
    rd(5);
    wr(5, 4'hF, 32'h0000_0000);
    rd(5);
    op(1'b1, 1'b0, 5, 4'h0, 32'h0, 32'h0, 32'h0000_0081);
    op(1'b1, 1'b0, 5, 4'h0, 32'h0, 32'h0000_0002, 32'h0000_0006);
    rd(5);

    curReq = "R9";
    wr(0, 4'b0100, 32'h0030_0000);
    op(1'b0, 1'b0, 0, 4'h0, 32'h0, 32'hFFFF_FFFF, 32'h0);
    wr(0, 4'b0100, 32'h0011_0000);
    rd(5);
    op(1'b0, 1'b0, 0, 4'h0, 32'h0, 32'h0000_00F0, 32'h0);
    op(1'b1, 1'b1, 2, 4'hF, 32'h0000_0001, 32'h0000_0080, 32'h0);
    rd(5);

    curReq = "R10";
    rd(6);
    wr(6, 4'hF, 32'hFFFF_FFFF);
    rd(63);
    wr(63, 4'hF, 32'hFFFF_FFFF);
    op(1'b0, 1'b0, 1, 4'h0, 32'h0, 32'h0, 32'h0);
    for (int a = 0; a < 8; a++) rd(a);

    curReq = "R11";
    wr(5, 4'h0, 32'h0);
    wr(0, 4'b1000, 32'hFF00_0000);
    idle();
    rd(0);

    curReq = "R12";
    for (int i = 0; i < 600; i++) begin
      op(1'b1, ($urandom % 2) == 0, int'($urandom_range(0, 7)), 4'($urandom),
         $urandom, (($urandom % 4) == 0) ? 32'($urandom) : 32'h0,
         (($urandom % 4) == 0) ? 32'($urandom) : 32'h0);
    end

    curReq = "R1";
    @(posedge clk);
    #2 rstN = 1'b0;
    idle();
    idle();
    rstN = 1'b1;
    for (int a = 0; a < 8; a++) rd(a);
    idle();
    @(posedge clk);
    #1;
    finishRun();
  end

  initial begin
    #500000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finished");
      finishRun();
    end
  end

endmodule